// File: doc/BRIEF.md
# Cipher Peripheral Event and Access-Violation Unit

This block is the status side of the register file for a 64-bit block-cipher peripheral. It keeps the interrupt source mask, which software sets through one write-one-to-set address and clears through a write-one-to-clear address. It keeps a data-ready flag raised by the cipher datapath and dropped when the result is read. It derives buffer-end and buffer-full/empty flags for the receive and transmit DMA channels from the counter values that the DMA engine exposes. It raises one registered interrupt line when any enabled source is active.

It also watches every bus access. An access that is illegal at that moment sets a sticky violation flag and overwrites a two-bit code naming the kind of violation. Illegal accesses are: a write-only register being read, the output data being read while processing, the mode register being written while processing, and the input data being written while processing in DMA mode. Only a software reset clears the flag and the code. The cipher datapath owns the key, data and vector storage. This block returns zero for every address except the mask and status words, so the datapath can OR its own read data onto the bus. The bus, the counters and the pulses are plain signals with no handshake: each access takes effect in the cycle its strobe is high.

Top module: `cphr_evt_unit`

## Requirements
- R1: After reset the mask word (0x18) and the status word (0x1C) read 0 (with all counters non-zero), and `irq` is 0.
- R2: A write to 0x10 sets each mask bit whose write-data bit is 1. A write to 0x14 clears each such bit. Bits written as 0 keep their value. Only bits 0, 1, 2, 3, 4 and 8 exist, and the mask reads back at 0x18.
- R3: Status bit 0 (data ready) goes to 1 on the edge that samples `done_pulse`. It goes to 0 on the edge that samples a read of 0x50 or 0x54. A set in the same cycle as a clear wins.
- R4: Status bit 1 (receive end) and bit 2 (transmit end) go to 1 one clock after the matching current counter reads zero. They go to 0 on the edge that samples the channel's load strobe, even if the counter is zero at that moment.
- R5: Status bit 3 is 1 exactly while both receive counters are zero. Status bit 4 is 1 exactly while both transmit counters are zero. Both bits follow the counters in the same cycle.
- R6: An illegal access sets status bit 8 and writes its code into status bits 13:12. The codes are: 3 for a read of a write-only address (0x00, 0x10, 0x14, 0x20..0x34, 0x40/0x44, 0x60/0x64); 1 for a read of 0x50/0x54 while `busy`; 2 for a write to 0x04 while `busy`; 0 for a write to 0x40/0x44 while both `busy` and `dma_mode` are high. A read check takes priority over a write check. Bit 8 stays 1 and the code changes only on a later violation.
- R7: Reading the status word changes none of its bits. A read of any address other than 0x18 and 0x1C returns 0 and, unless R6 names it, is not a violation.
- R8: A write to 0x00 with data bit 0 set clears the mask, data ready, bit 8 and bits 13:12 on that edge. A write to 0x00 with bit 0 clear changes none of them.
- R9: `irq` is the OR of (status bits AND mask bits), registered. It follows a status or mask change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading this block's words) |
| busy | input | 1 | Cipher is processing a block |
| dma_mode | input | 1 | Peripheral is fed by DMA |
| done_pulse | input | 1 | One-cycle pulse: output block is ready |
| rx_cnt | input | 16 | Receive current counter |
| rx_next_cnt | input | 16 | Receive next counter |
| rx_load | input | 1 | Receive counter register was written |
| tx_cnt | input | 16 | Transmit current counter |
| tx_next_cnt | input | 16 | Transmit next counter |
| tx_load | input | 1 | Transmit counter register was written |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong mask or a wrong sticky flag is visible at the next read of 0x18 or 0x1C. If that source is enabled, it is also visible on `irq` exactly one clock after the faulty edge. The buffer-end flags show a wrong register state as a status bit that is set or clear one cycle off from the counter transition. The full/empty bits have no state, so a decode error shows in the same cycle. A wrong violation priority or code appears only in bits 13:12 of the read after the offending access. For that reason each illegal pattern is followed at once by a status read.

// File: rtl/cphr_evt_pkg.sv
package cphr_evt_pkg;
  localparam int SRC_W   = 9;
  localparam int TYPE_LO = 12;
  localparam logic [SRC_W-1:0] SRC_VALID = 9'h11F;

  localparam int B_DRDY    = 0;
  localparam int B_RXEND   = 1;
  localparam int B_TXEND   = 2;
  localparam int B_RXFULL  = 3;
  localparam int B_TXEMPTY = 4;
  localparam int B_ILL     = 8;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_MODE   = 8'h04;
  localparam logic [7:0] A_IEN    = 8'h10;
  localparam logic [7:0] A_IDIS   = 8'h14;
  localparam logic [7:0] A_IMASK  = 8'h18;
  localparam logic [7:0] A_ISTAT  = 8'h1C;
  localparam logic [7:0] A_KEY_LO = 8'h20;
  localparam logic [7:0] A_KEY_HI = 8'h34;
  localparam logic [7:0] A_DIN    = 8'h40;
  localparam logic [7:0] A_DOUT   = 8'h50;
  localparam logic [7:0] A_IV     = 8'h60;

  typedef enum logic [1:0] {
    VIO_DIN_WR  = 2'd0,
    VIO_DOUT_RD = 2'd1,
    VIO_MODE_WR = 2'd2,
    VIO_WO_RD   = 2'd3
  } vio_e;
endpackage

// File: rtl/cphr_access_guard.sv
module cphr_access_guard
  import cphr_evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              busy,
  input  logic              dma_mode,
  input  logic              clr,
  output logic              ill_flag,
  output vio_e              ill_type
);
  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] base);
    return a == ADDR_W'(base);
  endfunction

  function automatic logic pair(input logic [ADDR_W-1:0] a, input logic [7:0] base);
    return at(a, base) || at(a, base + 8'd4);
  endfunction

  logic key_hit, wo_hit, dout_hit, din_hit, mode_hit;
  logic hit;
  vio_e code;

  always_comb begin
    key_hit  = (addr >= ADDR_W'(A_KEY_LO)) && (addr <= ADDR_W'(A_KEY_HI)) && (addr[1:0] == 2'b00);
    wo_hit   = at(addr, A_CTRL) || at(addr, A_IEN) || at(addr, A_IDIS) ||
               key_hit || pair(addr, A_DIN) || pair(addr, A_IV);
    dout_hit = pair(addr, A_DOUT);
    din_hit  = pair(addr, A_DIN);
    mode_hit = at(addr, A_MODE);
  end

  always_comb begin
    hit  = 1'b0;
    code = VIO_WO_RD;
    if (rd && wo_hit) begin
      hit  = 1'b1;
      code = VIO_WO_RD;
    end else if (rd && busy && dout_hit) begin
      hit  = 1'b1;
      code = VIO_DOUT_RD;
    end else if (wr && busy && mode_hit) begin
      hit  = 1'b1;
      code = VIO_MODE_WR;
    end else if (wr && busy && dma_mode && din_hit) begin
      hit  = 1'b1;
      code = VIO_DIN_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_flag <= 1'b0;
      ill_type <= VIO_DIN_WR;
    end else if (clr) begin
      ill_flag <= 1'b0;
      ill_type <= VIO_DIN_WR;
    end else if (hit) begin
      ill_flag <= 1'b1;
      ill_type <= code;
    end
  end
endmodule

// File: rtl/cphr_buf_flags.sv
module cphr_buf_flags #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0][CNT_W-1:0]  cur_cnt,
  input  logic [NCH-1:0][CNT_W-1:0]  nxt_cnt,
  input  logic [NCH-1:0]             load,
  output logic [NCH-1:0]             end_flag,
  output logic [NCH-1:0]             idle_flag
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic cur_zero;
    assign cur_zero     = (cur_cnt[c] == '0);
    assign idle_flag[c] = cur_zero && (nxt_cnt[c] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       end_flag[c] <= 1'b0;
      else if (load[c]) end_flag[c] <= 1'b0;
      else if (cur_zero) end_flag[c] <= 1'b1;
    end
  end
endmodule

// File: rtl/cphr_irq_core.sv
module cphr_irq_core
  import cphr_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en_wr,
  input  logic             dis_wr,
  input  logic [SRC_W-1:0] wbits,
  input  logic             done_pulse,
  input  logic             drdy_clr,
  input  logic [SRC_W-1:0] status,
  output logic [SRC_W-1:0] imr,
  output logic             drdy,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      imr <= '0;
    else if (clr)    imr <= '0;
    else if (en_wr)  imr <= imr | (wbits & SRC_VALID);
    else if (dis_wr) imr <= imr & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          drdy <= 1'b0;
    else if (clr)        drdy <= 1'b0;
    else if (done_pulse) drdy <= 1'b1;
    else if (drdy_clr)   drdy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & imr);
  end
endmodule

// File: rtl/cphr_evt_unit.sv
module cphr_evt_unit
  import cphr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              dma_mode,
  input  logic              done_pulse,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  rx_next_cnt,
  input  logic              rx_load,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  tx_next_cnt,
  input  logic              tx_load,
  output logic              irq
);
  localparam int NCH = 2;

  logic swrst, en_wr, dis_wr, dout_rd;
  logic [SRC_W-1:0] imr, stat_vec;
  logic drdy, ill_flag;
  vio_e ill_type;
  logic [NCH-1:0] buf_end, buf_idle;
  logic [DATA_W-1:0] stat_word;
  logic unused_wdata;

  assign swrst   = bus_wr && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[0];
  assign en_wr   = bus_wr && (bus_addr == ADDR_W'(A_IEN));
  assign dis_wr  = bus_wr && (bus_addr == ADDR_W'(A_IDIS));
  assign dout_rd = bus_rd && ((bus_addr == ADDR_W'(A_DOUT)) ||
                              (bus_addr == ADDR_W'(A_DOUT + 8'd4)));
  assign unused_wdata = ^bus_wdata[DATA_W-1:SRC_W];

  cphr_access_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .busy     (busy),
    .dma_mode (dma_mode),
    .clr      (swrst),
    .ill_flag (ill_flag),
    .ill_type (ill_type)
  );

  cphr_buf_flags #(.CNT_W(CNT_W), .NCH(NCH)) u_bufs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_cnt   ({tx_cnt, rx_cnt}),
    .nxt_cnt   ({tx_next_cnt, rx_next_cnt}),
    .load      ({tx_load, rx_load}),
    .end_flag  (buf_end),
    .idle_flag (buf_idle)
  );

  always_comb begin
    stat_vec            = '0;
    stat_vec[B_DRDY]    = drdy;
    stat_vec[B_RXEND]   = buf_end[0];
    stat_vec[B_TXEND]   = buf_end[1];
    stat_vec[B_RXFULL]  = buf_idle[0];
    stat_vec[B_TXEMPTY] = buf_idle[1];
    stat_vec[B_ILL]     = ill_flag;
  end

  cphr_irq_core u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (swrst),
    .en_wr      (en_wr),
    .dis_wr     (dis_wr),
    .wbits      (bus_wdata[SRC_W-1:0]),
    .done_pulse (done_pulse),
    .drdy_clr   (dout_rd),
    .status     (stat_vec),
    .imr        (imr),
    .drdy       (drdy),
    .irq        (irq)
  );

  always_comb begin
    stat_word                        = '0;
    stat_word[SRC_W-1:0]             = stat_vec;
    stat_word[TYPE_LO+1:TYPE_LO]     = ill_type;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(A_IMASK))      bus_rdata = DATA_W'(imr);
      else if (bus_addr == ADDR_W'(A_ISTAT)) bus_rdata = stat_word;
    end
  end
endmodule

// File: rtl/cphr_evt_chk.sv
module cphr_evt_chk
  import cphr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [SRC_W-1:0]  imr,
  input logic              ill_flag,
  input logic [1:0]        ill_type,
  input logic [1:0]        buf_end,
  input logic              rx_load,
  input logic              irq
);
  // R2
  en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_IEN)) |=>
      ((imr & $past(bus_wdata[SRC_W-1:0]) & SRC_VALID) == ($past(bus_wdata[SRC_W-1:0]) & SRC_VALID)));

  // R2
  dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_IDIS)) |=> ((imr & $past(bus_wdata[SRC_W-1:0])) == '0));

  // R6
  ill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_flag && !(bus_wr && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[0])) |=> ill_flag);

  // R6
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'(A_KEY_LO) || bus_addr == ADDR_W'(A_IEN))) |=>
      (ill_flag && ill_type == 2'd3));

  // R4
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> !buf_end[0]);

  // R8
  swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[0]) |=> (imr == '0 && !ill_flag));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '0) |=> !irq);
endmodule

bind cphr_evt_unit cphr_evt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .imr       (imr),
  .ill_flag  (ill_flag),
  .ill_type  (ill_type),
  .buf_end   (buf_end),
  .rx_load   (rx_load),
  .irq       (irq)
);

// File: tb/cphr_evt_unit_tb.sv
`timescale 1ns/1ps
module cphr_evt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy = 1'b0, dma_mode = 1'b0, done_pulse = 1'b0;
  logic [15:0] rx_cnt = 16'd3, rx_next_cnt = 16'd3, tx_cnt = 16'd3, tx_next_cnt = 16'd3;
  logic        rx_load = 1'b0, tx_load = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cphr_evt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .dma_mode(dma_mode),
    .done_pulse(done_pulse), .rx_cnt(rx_cnt), .rx_next_cnt(rx_next_cnt), .rx_load(rx_load),
    .tx_cnt(tx_cnt), .tx_next_cnt(tx_next_cnt), .tx_load(tx_load), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 idle, 1 write, 2 read
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        bsy;
    logic        dma;
    logic [7:0]  chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{2'd1, 8'h10, 32'h0000_011F, 1'b0, 1'b0, 8'h18, 32'h0000_011F, 4'd2}, // R2 enable
    '{2'd1, 8'h14, 32'h0000_0006, 1'b0, 1'b0, 8'h18, 32'h0000_0119, 4'd2}, // R2 disable
    '{2'd1, 8'h10, 32'hFFFF_FE00, 1'b0, 1'b0, 8'h18, 32'h0000_0119, 4'd2}, // R2 undefined bits
    '{2'd2, 8'h20, 32'h0,         1'b0, 1'b0, 8'h1C, 32'h0000_3100, 4'd6}, // R6 write-only read
    '{2'd1, 8'h04, 32'h0,         1'b1, 1'b0, 8'h1C, 32'h0000_2100, 4'd6}, // R6 mode write busy
    '{2'd2, 8'h50, 32'h0,         1'b1, 1'b0, 8'h1C, 32'h0000_1100, 4'd6}, // R6 output read busy
    '{2'd1, 8'h40, 32'h0,         1'b1, 1'b1, 8'h1C, 32'h0000_0100, 4'd6}, // R6 input write dma
    '{2'd1, 8'h44, 32'h0,         1'b1, 1'b0, 8'h1C, 32'h0000_0100, 4'd6}, // R6 legal without dma
    '{2'd1, 8'h04, 32'h0,         1'b0, 1'b0, 8'h1C, 32'h0000_0100, 4'd6}, // R6 legal when idle
    '{2'd2, 8'h1C, 32'h0,         1'b0, 1'b0, 8'h1C, 32'h0000_0100, 4'd7}, // R7 status read keeps
    '{2'd2, 8'h34, 32'h0,         1'b0, 1'b0, 8'h1C, 32'h0000_3100, 4'd6}, // R6 key word read
    '{2'd1, 8'h00, 32'h0000_0002, 1'b0, 1'b0, 8'h1C, 32'h0000_3100, 4'd8}, // R8 no reset bit
    '{2'd1, 8'h00, 32'h0000_0001, 1'b0, 1'b0, 8'h1C, 32'h0000_0000, 4'd8}, // R8 reset status
    '{2'd0, 8'h00, 32'h0,         1'b0, 1'b0, 8'h18, 32'h0000_0000, 4'd8}, // R8 reset mask
    '{2'd2, 8'h7C, 32'h0,         1'b0, 1'b0, 8'h1C, 32'h0000_0000, 4'd7}  // R7 undefined read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [1:0] kind, input logic [7:0] a, input logic [31:0] d,
                           input logic b, input logic m);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; busy = b; dma_mode = m;
    bus_wr = (kind == 2'd1);
    bus_rd = (kind == 2'd2);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; busy = 1'b0; dma_mode = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(tag, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_check(8'h1C, 32'h0, "R1 status after reset");
    rd_check(8'h18, 32'h0, "R1 mask after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_access(VT[i].kind, VT[i].addr, VT[i].wdata, VT[i].bsy, VT[i].dma);
      rd_check(VT[i].chk, VT[i].exp, $sformatf("R%0d vector %0d", VT[i].req, i));
    end

    // R3 / R9 data ready and interrupt latency
    do_access(2'd1, 8'h10, 32'h1, 1'b0, 1'b0);
    @(negedge clk); done_pulse = 1'b1;
    @(negedge clk); done_pulse = 1'b0;
    rd_check(8'h1C, 32'h1, "R3 data ready set");
    chk("R9 irq one clock late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    do_access(2'd2, 8'h50, 32'h0, 1'b0, 1'b0);
    rd_check(8'h1C, 32'h0, "R3 data ready cleared by output read");
    chk("R9 irq holds one clock", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);

    // R4 / R5 buffer flags
    do_access(2'd1, 8'h14, 32'h1F, 1'b0, 1'b0);
    rx_cnt = 16'd0;
    rd_check(8'h1C, 32'h0, "R4 receive end not yet set");
    @(negedge clk);
    rd_check(8'h1C, 32'h2, "R4 receive end set");
    rx_next_cnt = 16'd0;
    rd_check(8'h1C, 32'hA, "R5 receive full");
    chk("R9 masked source keeps irq low", {31'b0, irq}, 32'h0);
    rx_cnt = 16'd7; rx_load = 1'b1;
    @(negedge clk); rx_load = 1'b0;
    rd_check(8'h1C, 32'h0, "R4 receive end cleared by load");
    tx_cnt = 16'd0; tx_next_cnt = 16'd0;
    rd_check(8'h1C, 32'h10, "R5 transmit empty same cycle");
    @(negedge clk);
    rd_check(8'h1C, 32'h14, "R4 transmit end set");
    tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
    rd_check(8'h1C, 32'h10, "R4 load clears even at zero");
    @(negedge clk);
    rd_check(8'h1C, 32'h14, "R4 transmit end sets again");
    do_access(2'd1, 8'h10, 32'h4, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 irq from transmit end", {31'b0, irq}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule